// File: doc/BRIEF.md
# Burst Packet Stream Source

This block is a hardware traffic source. A single-cycle start request carries a set of burst parameters, and the block then emits that many framed packets on a 64-bit AXI4-Stream master port. Each packet has a header beat, an optional 64-bit timestamp beat on the first packet, and a payload made of pairs of 32-bit sample values. The block is used as a stimulus or test-pattern engine in front of packet-processing logic that expects well-formed headers.

The burst parameters are the packet count, the payload length in 32-bit words, a timestamp, a time-enable flag, a starting sequence number, a stream identifier, a payload mode and a 16-bit counter seed. The block decides at the first packet whether the timestamp goes in and raises end-of-burst on the last packet. The header length field counts the time word when it is present. A `busy` level and a one-cycle `done` pulse let the requester pace its bursts.

Top module: `burst_stream_gen`

## Requirements
- R1: A header beat is laid out as: bit 63 = 0, bit 62 = 0, bit 61 = has-time, bit 60 = end-of-burst, bits [59:48] = sequence number, bits [47:32] = length field, bits [31:0] = stream identifier.
- R2: The length field equals the payload length plus 2, plus a further 2 when the packet has a timestamp, modulo 2^16. A requested payload length of 0 is treated as 1.
- R3: When time-enable is set, the first packet of a burst has has-time = 1 and the beat right after its header is the 64-bit timestamp. No other packet has has-time set or a timestamp beat.
- R4: End-of-burst is 1 only in the header of the last packet of a burst. A one-packet burst has it set on that packet.
- R5: The first packet carries the starting sequence number. Each later packet carries the previous value plus one, wrapping modulo 4096.
- R6: The payload takes ceil(len/2) beats. Each beat is {n, n+1}, with n in bits [63:32] and n+1 in bits [31:0], and n grows by 2 per beat. `m_tlast` is 1 on the final payload beat of each packet and on no other beat.
- R7: In ramp mode (mode = 0), the first sample of packet k of a burst is k*len, so the first packet starts at 0.
- R8: In counter mode (mode = 1), the first sample of each packet is {4'b0, sequence number, seed[15:0]}.
- R9: While `m_tvalid` is 1 and `m_tready` is 0, `m_tvalid`, `m_tdata` and `m_tlast` hold their values, and the stream advances only on a cycle where both are 1.
- R10: A start request while `busy` is 1 is ignored. The running burst completes unchanged and no further beats follow it.
- R11: After reset, `busy`, `done` and `m_tvalid` are 0. `done` is a one-cycle pulse in the cycle after the last beat of a burst is accepted, and `busy` is 0 in that cycle.
- R12: A start with a packet count of 0 produces no beats. `done` pulses in the cycle after the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Burst request, sampled while idle |
| cfg_count | input | CNT_W | Packets in the burst |
| cfg_len | input | 16 | Payload length in 32-bit words |
| cfg_time | input | 64 | Timestamp for the first packet |
| cfg_time_en | input | 1 | Include the timestamp on the first packet |
| cfg_seq | input | 12 | Starting sequence number |
| cfg_sid | input | 32 | Stream identifier for every header |
| cfg_mode | input | 1 | Payload mode: 0 ramp, 1 counter |
| cfg_seed | input | 16 | Low half of the counter-mode first sample |
| m_tdata | output | 64 | Stream data |
| m_tlast | output | 1 | Final payload beat of a packet |
| m_tvalid | output | 1 | Stream data valid |
| m_tready | input | 1 | Downstream ready |
| busy | output | 1 | Burst in progress |
| done | output | 1 | One-cycle burst completion pulse |

## Verification
A start that is accepted at a clock edge puts the first header on the port at that same edge, so the header can be read at the next falling edge. Every later beat appears on the edge that accepts the one before it. The `done` pulse, together with the fall of `busy`, is due one edge after the last beat is accepted, and with a zero count it is due one edge after the start. The bench drives `m_tready` and reads the outputs at falling edges. It compares a beat only when valid and ready are both high, checks the held data one falling edge after a stall, and samples `done` exactly one and two falling edges after the final handshake.

// File: rtl/burst_gen_pkg.sv
package burst_gen_pkg;

    localparam int WORD_W = 64;
    localparam int SAMP_W = 32;
    localparam int SEQ_W  = 12;
    localparam int LEN_W  = 16;
    localparam int SID_W  = 32;
    localparam int SEED_W = 16;
    localparam int PAD_W  = SAMP_W - SEQ_W - SEED_W;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HDR  = 2'd1,
        PH_TIME = 2'd2,
        PH_PAY  = 2'd3
    } phase_e;

    typedef enum logic {
        MODE_RAMP  = 1'b0,
        MODE_COUNT = 1'b1
    } pay_mode_e;

    typedef struct packed {
        logic             has_time;
        logic             eob;
        logic [SEQ_W-1:0] seq;
        logic [LEN_W-1:0] len_words;
        logic [SID_W-1:0] sid;
    } hdr_t;

    // Zero-length payload requests behave as one word.
    function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] w);
        return (w == '0) ? LEN_W'(1) : w;
    endfunction

    function automatic logic [LEN_W-1:0] len_field(input logic [LEN_W-1:0] pay,
                                                   input logic ht);
        return pay + LEN_W'(2) + (ht ? LEN_W'(2) : LEN_W'(0));
    endfunction

    function automatic logic [LEN_W-1:0] beat_count(input logic [LEN_W-1:0] pay);
        return {1'b0, pay[LEN_W-1:1]} + {{(LEN_W-1){1'b0}}, pay[0]};
    endfunction

    function automatic logic [WORD_W-1:0] pack_hdr(input hdr_t h);
        return {1'b0, 1'b0, h.has_time, h.eob, h.seq, h.len_words, h.sid};
    endfunction

    function automatic logic [SAMP_W-1:0] count_base(input logic [SEQ_W-1:0] s,
                                                     input logic [SEED_W-1:0] seed);
        return {{PAD_W{1'b0}}, s, seed};
    endfunction

endpackage

// File: rtl/burst_hdr_fmt.sv
module burst_hdr_fmt
    import burst_gen_pkg::*;
(
    input  logic              has_time,
    input  logic              eob,
    input  logic [SEQ_W-1:0]  seq,
    input  logic [LEN_W-1:0]  pay_len,
    input  logic [SID_W-1:0]  sid,
    output logic [WORD_W-1:0] word
);
    hdr_t h;

    always_comb begin
        h.has_time  = has_time;
        h.eob       = eob;
        h.seq       = seq;
        h.len_words = len_field(pay_len, has_time);
        h.sid       = sid;
        word        = pack_hdr(h);
    end
endmodule

// File: rtl/burst_sample_ctr.sv
module burst_sample_ctr
    import burst_gen_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              ld_mode,
    input  logic [SEQ_W-1:0]  ld_seq,
    input  logic [SEED_W-1:0] ld_seed,
    input  logic [LEN_W-1:0]  ld_len,
    input  logic              step,
    input  logic              next_pkt,
    input  logic [SEQ_W-1:0]  next_seq,
    output logic [SAMP_W-1:0] sample
);
    pay_mode_e         mode_q;
    logic [SEED_W-1:0] seed_q;
    logic [LEN_W-1:0]  len_q;
    logic [SAMP_W-1:0] base_q;
    logic [SAMP_W-1:0] n_q;
    logic [SAMP_W-1:0] first_base;
    logic [SAMP_W-1:0] next_base;

    always_comb begin
        first_base = ld_mode ? count_base(ld_seq, ld_seed) : '0;
        if (mode_q == MODE_COUNT)
            next_base = count_base(next_seq, seed_q);
        else
            next_base = base_q + {{(SAMP_W-LEN_W){1'b0}}, len_q};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_RAMP;
            seed_q <= '0;
            len_q  <= '0;
            base_q <= '0;
            n_q    <= '0;
        end else if (load) begin
            mode_q <= pay_mode_e'(ld_mode);
            seed_q <= ld_seed;
            len_q  <= ld_len;
            base_q <= first_base;
            n_q    <= first_base;
        end else if (next_pkt) begin
            base_q <= next_base;
            n_q    <= next_base;
        end else if (step) begin
            n_q    <= n_q + SAMP_W'(2);
        end
    end

    assign sample = n_q;
endmodule

// File: rtl/burst_seq_fsm.sv
module burst_seq_fsm
    import burst_gen_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] cfg_count,
    input  logic [LEN_W-1:0] cfg_len,
    input  logic             cfg_time_en,
    input  logic [SEQ_W-1:0] cfg_seq,
    input  logic             fire,
    output phase_e           phase,
    output logic [SEQ_W-1:0] seq,
    output logic [SEQ_W-1:0] next_seq,
    output logic [LEN_W-1:0] pay_len,
    output logic             has_time,
    output logic             eob,
    output logic             last_beat,
    output logic             load,
    output logic             step,
    output logic             next_pkt,
    output logic             done
);
    phase_e           phase_q;
    logic [CNT_W-1:0] pkts_left_q;
    logic [LEN_W-1:0] beats_left_q;
    logic [SEQ_W-1:0] seq_q;
    logic [LEN_W-1:0] len_q;
    logic             first_q;
    logic             time_en_q;
    logic             done_q;
    logic             accept;
    logic             fire_pay;

    always_comb begin
        accept    = start && (phase_q == PH_IDLE);
        load      = accept && (cfg_count != '0);
        has_time  = first_q && time_en_q;
        eob       = (pkts_left_q == CNT_W'(1));
        last_beat = (phase_q == PH_PAY) && (beats_left_q == LEN_W'(1));
        fire_pay  = fire && (phase_q == PH_PAY);
        step      = fire_pay && !last_beat;
        next_pkt  = fire_pay && last_beat && !eob;
        next_seq  = seq_q + SEQ_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q      <= PH_IDLE;
            pkts_left_q  <= '0;
            beats_left_q <= '0;
            seq_q        <= '0;
            len_q        <= '0;
            first_q      <= 1'b0;
            time_en_q    <= 1'b0;
            done_q       <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (phase_q)
                PH_IDLE: begin
                    if (accept) begin
                        if (cfg_count == '0) begin
                            done_q <= 1'b1;
                        end else begin
                            phase_q     <= PH_HDR;
                            pkts_left_q <= cfg_count;
                            seq_q       <= cfg_seq;
                            len_q       <= clamp_len(cfg_len);
                            first_q     <= 1'b1;
                            time_en_q   <= cfg_time_en;
                        end
                    end
                end
                PH_HDR: begin
                    if (fire) begin
                        beats_left_q <= beat_count(len_q);
                        phase_q      <= has_time ? PH_TIME : PH_PAY;
                    end
                end
                PH_TIME: begin
                    if (fire) phase_q <= PH_PAY;
                end
                PH_PAY: begin
                    if (fire) begin
                        if (beats_left_q == LEN_W'(1)) begin
                            if (eob) begin
                                phase_q <= PH_IDLE;
                                done_q  <= 1'b1;
                            end else begin
                                pkts_left_q <= pkts_left_q - CNT_W'(1);
                                seq_q       <= next_seq;
                                first_q     <= 1'b0;
                                phase_q     <= PH_HDR;
                            end
                        end else begin
                            beats_left_q <= beats_left_q - LEN_W'(1);
                        end
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign phase   = phase_q;
    assign seq     = seq_q;
    assign pay_len = len_q;
    assign done    = done_q;
endmodule

// File: rtl/burst_stream_gen.sv
module burst_stream_gen
    import burst_gen_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] cfg_count,
    input  logic [15:0]      cfg_len,
    input  logic [63:0]      cfg_time,
    input  logic             cfg_time_en,
    input  logic [11:0]      cfg_seq,
    input  logic [31:0]      cfg_sid,
    input  logic             cfg_mode,
    input  logic [15:0]      cfg_seed,
    output logic [63:0]      m_tdata,
    output logic             m_tlast,
    output logic             m_tvalid,
    input  logic             m_tready,
    output logic             busy,
    output logic             done
);
    phase_e            phase;
    logic [SEQ_W-1:0]  seq;
    logic [SEQ_W-1:0]  next_seq;
    logic [LEN_W-1:0]  pay_len;
    logic              has_time;
    logic              eob;
    logic              last_beat;
    logic              load;
    logic              step;
    logic              next_pkt;
    logic              fire;
    logic [SAMP_W-1:0] sample;
    logic [WORD_W-1:0] hdr_word;
    logic [WORD_W-1:0] time_q;
    logic [SID_W-1:0]  sid_q;

    assign m_tvalid = (phase != PH_IDLE);
    assign fire     = m_tvalid && m_tready;
    assign busy     = m_tvalid;
    assign m_tlast  = last_beat;

    burst_seq_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .cfg_count  (cfg_count),
        .cfg_len    (cfg_len),
        .cfg_time_en(cfg_time_en),
        .cfg_seq    (cfg_seq),
        .fire       (fire),
        .phase      (phase),
        .seq        (seq),
        .next_seq   (next_seq),
        .pay_len    (pay_len),
        .has_time   (has_time),
        .eob        (eob),
        .last_beat  (last_beat),
        .load       (load),
        .step       (step),
        .next_pkt   (next_pkt),
        .done       (done)
    );

    burst_sample_ctr u_samp (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .ld_mode (cfg_mode),
        .ld_seq  (cfg_seq),
        .ld_seed (cfg_seed),
        .ld_len  (clamp_len(cfg_len)),
        .step    (step),
        .next_pkt(next_pkt),
        .next_seq(next_seq),
        .sample  (sample)
    );

    burst_hdr_fmt u_hdr (
        .has_time(has_time),
        .eob     (eob),
        .seq     (seq),
        .pay_len (pay_len),
        .sid     (sid_q),
        .word    (hdr_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            time_q <= '0;
            sid_q  <= '0;
        end else if (load) begin
            time_q <= cfg_time;
            sid_q  <= cfg_sid;
        end
    end

    always_comb begin
        unique case (phase)
            PH_HDR:  m_tdata = hdr_word;
            PH_TIME: m_tdata = time_q;
            PH_PAY:  m_tdata = {sample, sample + SAMP_W'(1)};
            default: m_tdata = '0;
        endcase
    end
endmodule

// File: rtl/burst_gen_checker.sv
module burst_gen_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic [CNT_W-1:0] cfg_count,
    input logic [11:0]      cfg_seq,
    input logic [63:0]      m_tdata,
    input logic             m_tlast,
    input logic             m_tvalid,
    input logic             m_tready,
    input logic             busy,
    input logic             done
);
    assert_hold_stalled_R9: assert property (@(posedge clk) disable iff (rst)
        (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tlast)));

    assert_last_needs_valid_R6: assert property (@(posedge clk) disable iff (rst)
        m_tlast |-> m_tvalid);

    assert_done_single_R11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_idle_R11: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && !m_tvalid));

    assert_busy_end_R11: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    assert_zero_count_R12: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && cfg_count == '0) |=> (done && !m_tvalid));

    assert_first_seq_R5: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && cfg_count != '0) |=> (m_tvalid && m_tdata[59:48] == $past(cfg_seq)));

    assert_busy_start_ignored_R10: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !(m_tready && m_tlast)) |=> busy);
endmodule

bind burst_stream_gen burst_gen_checker #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .cfg_count(cfg_count),
    .cfg_seq  (cfg_seq),
    .m_tdata  (m_tdata),
    .m_tlast  (m_tlast),
    .m_tvalid (m_tvalid),
    .m_tready (m_tready),
    .busy     (busy),
    .done     (done)
);

// File: tb/test_burst_stream_gen.sv
module test_burst_stream_gen;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic [CNT_W-1:0] cfg_count = '0;
    logic [15:0]      cfg_len = '0;
    logic [63:0]      cfg_time = '0;
    logic             cfg_time_en = 1'b0;
    logic [11:0]      cfg_seq = '0;
    logic [31:0]      cfg_sid = '0;
    logic             cfg_mode = 1'b0;
    logic [15:0]      cfg_seed = '0;
    logic [63:0]      m_tdata;
    logic             m_tlast;
    logic             m_tvalid;
    logic             m_tready = 1'b0;
    logic             busy;
    logic             done;

    int checks = 0;
    int errors = 0;

    logic [63:0] exp_d[$];
    logic        exp_l[$];
    int          exp_k[$];

    always #2 clk = ~clk;

    burst_stream_gen #(.CNT_W(CNT_W)) i_burst_stream_gen (
        .clk(clk), .rst(rst), .start(start), .cfg_count(cfg_count),
        .cfg_len(cfg_len), .cfg_time(cfg_time), .cfg_time_en(cfg_time_en),
        .cfg_seq(cfg_seq), .cfg_sid(cfg_sid), .cfg_mode(cfg_mode),
        .cfg_seed(cfg_seed), .m_tdata(m_tdata), .m_tlast(m_tlast),
        .m_tvalid(m_tvalid), .m_tready(m_tready), .busy(busy), .done(done)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference stream built from the requirements.
    task automatic build_expect(input int cnt, input int len, input logic [63:0] ts,
                                input bit ten, input int seq0, input logic [31:0] sid,
                                input bit mode, input logic [15:0] seed);
        int l;
        exp_d.delete(); exp_l.delete(); exp_k.delete();
        l = (len == 0) ? 1 : len;
        for (int p = 0; p < cnt; p++) begin
            logic [11:0] s;
            logic [15:0] lf;
            logic [31:0] base;
            bit ht, eob;
            s   = 12'((seq0 + p) % 4096);
            ht  = ten && (p == 0);
            eob = (p == cnt - 1);
            lf  = 16'(l + 2 + (ht ? 2 : 0));
            exp_d.push_back({1'b0, 1'b0, ht, eob, s, lf, sid});
            exp_l.push_back(1'b0); exp_k.push_back(0);
            if (ht) begin
                exp_d.push_back(ts); exp_l.push_back(1'b0); exp_k.push_back(1);
            end
            base = mode ? {4'b0, s, seed} : 32'(p * l);
            for (int b = 0; b < (l + 1) / 2; b++) begin
                logic [31:0] n;
                n = base + 32'(2 * b);
                exp_d.push_back({n, n + 32'd1});
                exp_l.push_back(b == (l + 1) / 2 - 1);
                exp_k.push_back(2);
            end
        end
    endtask

    // Issue a burst, collect it under a ready pattern, check beats and done.
    task automatic run_burst(input string name, input int cnt, input int len,
                             input logic [63:0] ts, input bit ten, input int seq0,
                             input logic [31:0] sid, input bit mode,
                             input logic [15:0] seed, input int rdy_pat, input bit poke);
        int idx = 0;
        int guard = 0;
        int cyc = 0;
        bit have_hold = 0;
        logic [63:0] held = '0;
        build_expect(cnt, len, ts, ten, seq0, sid, mode, seed);
        @(negedge clk);
        cfg_count = CNT_W'(cnt); cfg_len = 16'(len); cfg_time = ts;
        cfg_time_en = ten; cfg_seq = 12'(seq0); cfg_sid = sid;
        cfg_mode = mode; cfg_seed = seed; start = 1'b1;
        while (idx < exp_d.size() && guard < 4000) begin
            @(negedge clk);
            guard++; cyc++;
            if (poke && idx == 2) begin
                start = 1'b1; cfg_count = 16'd9; cfg_seq = 12'h123; cfg_sid = 32'hDEAD;
            end else begin
                start = 1'b0;
            end
            if (have_hold) begin
                check(m_tvalid && m_tdata == held, {name, " R9 held data"}, m_tdata, held);
                have_hold = 0;
            end
            m_tready = (rdy_pat == 0) ? 1'b1 : ((cyc % 3) != 0);
            if (m_tvalid && !m_tready) begin
                have_hold = 1; held = m_tdata;
            end
            if (m_tvalid && m_tready) begin
                case (exp_k[idx])
                    0: check(m_tdata == exp_d[idx], {name, " R1 R2 R4 R5 header"}, m_tdata, exp_d[idx]);
                    1: check(m_tdata == exp_d[idx], {name, " R3 timestamp"}, m_tdata, exp_d[idx]);
                    default: check(m_tdata == exp_d[idx], {name, " R6 R7 R8 payload"}, m_tdata, exp_d[idx]);
                endcase
                check(m_tlast == exp_l[idx], {name, " R6 tlast"}, 64'(m_tlast), 64'(exp_l[idx]));
                idx++;
            end
        end
        check(idx == exp_d.size(), {name, " R6 beat count"}, 64'(idx), 64'(exp_d.size()));
        @(negedge clk);
        start = 1'b0; m_tready = 1'b0;
        check(done && !busy && !m_tvalid, {name, " R11 done pulse"},
              {61'b0, done, busy, m_tvalid}, 64'h4);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(!done && !m_tvalid, {name, " R10 R11 quiet after burst"},
                  {62'b0, done, m_tvalid}, 64'h0);
        end
    endtask

    task automatic t_reset;
        check(!busy && !done && !m_tvalid, "R11 reset state",
              {61'b0, busy, done, m_tvalid}, 64'h0);
    endtask

    task automatic t_zero_count;
        @(negedge clk);
        cfg_count = '0; cfg_len = 16'd4; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(done && !m_tvalid && !busy, "R12 zero count done",
              {61'b0, done, m_tvalid, busy}, 64'h4);
        @(negedge clk);
        check(!done && !m_tvalid, "R12 zero count no beats",
              {62'b0, done, m_tvalid}, 64'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        run_burst("single_timed", 1, 4, 64'h0123_4567_89AB_CDEF, 1'b1, 12'h010,
                  32'h0000_00AA, 1'b0, 16'h0, 0, 1'b0);
        run_burst("ramp_odd_stall", 3, 5, 64'hFEED_0000_0000_0001, 1'b1, 12'h7F0,
                  32'h1234_5678, 1'b0, 16'h0, 1, 1'b0);
        run_burst("counter_wrap", 4, 2, 64'h0, 1'b0, 12'hFFE,
                  32'hCAFE_0001, 1'b1, 16'hBEEF, 0, 1'b0);
        t_zero_count();
        run_burst("busy_start", 2, 3, 64'h0, 1'b0, 12'h005,
                  32'h0000_0077, 1'b1, 16'h1111, 1, 1'b1);
        run_burst("len_zero", 2, 0, 64'h0, 1'b0, 12'h000,
                  32'h0000_0042, 1'b0, 16'h0, 0, 1'b0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule